// File: doc/BRIEF.md
# Physical Frame Bitmap Allocator

This block keeps track of which physical memory frames are taken, using one bit of state per frame: a set bit marks a frame in use and a clear bit marks a free one. Software or a memory manager asks for a number of frames. The block either grants the whole request or refuses it outright. A grant is a stream of frame numbers, one per clock, chosen lowest index first. The frames may lie anywhere in memory and need not be adjacent.

A running count of free frames is held next to the bitmap. An allocation is judged against this count before any bit is touched, so a refused request leaves no trace. Frames are returned one at a time by number. Returning a frame that is already free raises an error pulse and changes nothing. While a grant is streaming out, the block reports itself busy and ignores any new request.

Top module: `frame_bitmap_alloc`

## Requirements
- R1: After synchronous reset every frame is free, `free_count` equals NUM_FRAMES, and `busy`, `grant_valid`, `grant_last`, `alloc_reject` and `free_err` are all 0.
- R2: `free_count` always equals the number of free frames in the bitmap.
- R3: A request of N frames, sampled while idle at clock edge k, is accepted when 1 <= N <= `free_count`. `busy` is 1 from edge k onward, and exactly N grants appear, one after each of edges k+1 to k+N, with `grant_valid` high on consecutive cycles.
- R4: Each grant gives the lowest-numbered frame that is free at that moment. Granted frames need not be contiguous. Each grant marks its frame used and lowers `free_count` by one.
- R5: `grant_last` is 1 together with the Nth grant only. `busy` is 0 from that same cycle.
- R6: A request with N = 0 or N > `free_count` raises `alloc_reject` for one cycle after edge k. It changes neither the bitmap nor `free_count`.
- R7: A return of a used frame clears its bit and raises `free_count` by one after the sampling edge. A return of a frame that is already free, or that is out of range, raises `free_err` for one cycle and changes nothing.
- R8: While `busy` is 1, `alloc_req` and `free_req` are ignored.
- R9: When idle, if `alloc_req` and `free_req` are high in the same cycle, the allocation is served and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation request, sampled when idle |
| alloc_num | input | CNT_W | Number of frames asked for |
| free_req | input | 1 | Return request, sampled when idle and no allocation request |
| free_frame | input | IDX_W | Frame number being returned |
| busy | output | 1 | A grant stream is in progress |
| alloc_reject | output | 1 | One-cycle pulse: request refused |
| grant_valid | output | 1 | `grant_frame` carries a granted frame |
| grant_frame | output | IDX_W | Granted frame number |
| grant_last | output | 1 | Final grant of the stream |
| free_err | output | 1 | One-cycle pulse: invalid return |
| free_count | output | CNT_W | Number of free frames |

## Verification
The bench builds the block with eight frames, so IDX_W is 3 and CNT_W is 4. With this size a few requests drain the pool to zero. Refusal at the exact boundary (asking for one more than is free, and asking when none are free) and refill after a return are therefore reached in a short directed run. The small pool also quickly breaks up the used frames into scattered holes. This shows lowest-first selection skipping used frames, and shows returns and refused requests interleaved with active streams.

// File: rtl/fba_pkg.sv
package fba_pkg;

    typedef enum logic {
        FBA_IDLE   = 1'b0,
        FBA_STREAM = 1'b1
    } fba_state_e;

    typedef struct packed {
        logic req;
        logic err;
    } fba_event_t;

endpackage

// File: rtl/fba_lowest_free.sv
module fba_lowest_free #(
    parameter int NUM_FRAMES = 64,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0] used,
    output logic                  found,
    output logic [IDX_W-1:0]      idx
);
    // Scan from the top down so the last hit written is the lowest free frame.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fba_bitmap.sv
module fba_bitmap #(
    parameter int NUM_FRAMES = 64,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_idx,
    output logic [NUM_FRAMES-1:0] used
);
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                used[g] <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(g))) begin
                used[g] <= 1'b1;
            end else if (clr_en && (clr_idx == IDX_W'(g))) begin
                used[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/frame_bitmap_alloc.sv
module frame_bitmap_alloc
    import fba_pkg::*;
#(
    parameter int NUM_FRAMES = 64,
    parameter int IDX_W      = $clog2(NUM_FRAMES),
    parameter int CNT_W      = $clog2(NUM_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic [CNT_W-1:0] alloc_num,
    input  logic             free_req,
    input  logic [IDX_W-1:0] free_frame,
    output logic             busy,
    output logic             alloc_reject,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_frame,
    output logic             grant_last,
    output logic             free_err,
    output logic [CNT_W-1:0] free_count
);
    localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(NUM_FRAMES);

    fba_state_e            state_q;
    logic [CNT_W-1:0]      remain_q;
    logic [CNT_W-1:0]      count_q;
    logic [NUM_FRAMES-1:0] map_q;
    logic                  low_found;
    logic [IDX_W-1:0]      low_idx;

    logic       idle;
    logic       accept;
    fba_event_t alloc_ev;
    fba_event_t free_ev;
    logic       free_hit;
    logic       step;

    fba_lowest_free #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) finder_i (
        .used  (map_q),
        .found (low_found),
        .idx   (low_idx)
    );

    assign idle   = (state_q == FBA_IDLE);
    assign accept = idle && alloc_req && (alloc_num != '0) && (alloc_num <= count_q);
    assign step   = (state_q == FBA_STREAM) && low_found;

    always_comb begin
        alloc_ev.req = idle && alloc_req;
        alloc_ev.err = idle && alloc_req && !accept;
        free_ev.req  = idle && !alloc_req && free_req;
        free_hit     = 1'b0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (free_frame == IDX_W'(i)) begin
                free_hit = map_q[i];
            end
        end
        free_ev.err  = free_ev.req && !free_hit;
    end

    fba_bitmap #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) bitmap_i (
        .clk     (clk),
        .rst     (rst),
        .set_en  (step),
        .set_idx (low_idx),
        .clr_en  (free_ev.req && free_hit),
        .clr_idx (free_frame),
        .used    (map_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= FBA_IDLE;
            remain_q     <= '0;
            count_q      <= FULL_COUNT;
            grant_valid  <= 1'b0;
            grant_frame  <= '0;
            grant_last   <= 1'b0;
            alloc_reject <= 1'b0;
            free_err     <= 1'b0;
        end else begin
            grant_valid  <= step;
            grant_frame  <= low_idx;
            grant_last   <= step && (remain_q == CNT_W'(1));
            alloc_reject <= alloc_ev.err;
            free_err     <= free_ev.err;

            if (step) begin
                count_q <= count_q - CNT_W'(1);
            end else if (free_ev.req && free_hit) begin
                count_q <= count_q + CNT_W'(1);
            end

            case (state_q)
                FBA_IDLE: begin
                    if (accept) begin
                        state_q  <= FBA_STREAM;
                        remain_q <= alloc_num;
                    end
                end
                FBA_STREAM: begin
                    remain_q <= remain_q - CNT_W'(1);
                    if (remain_q == CNT_W'(1)) begin
                        state_q <= FBA_IDLE;
                    end
                end
                default: state_q <= FBA_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == FBA_STREAM);
    assign free_count = count_q;

endmodule

// File: rtl/fba_checker.sv
module fba_checker #(
    parameter int NUM_FRAMES = 64,
    parameter int IDX_W      = $clog2(NUM_FRAMES),
    parameter int CNT_W      = $clog2(NUM_FRAMES + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  busy,
    input logic                  alloc_reject,
    input logic                  grant_valid,
    input logic [IDX_W-1:0]      grant_frame,
    input logic                  grant_last,
    input logic                  free_err,
    input logic [CNT_W-1:0]      free_count,
    input logic [NUM_FRAMES-1:0] map
);
    a_r2_count_tracks_map: assert property (@(posedge clk) disable iff (rst)
        int'(free_count) == NUM_FRAMES - $countones(map));

    a_r4_grant_marked_used: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> map[grant_frame]);

    a_r3_stream_unbroken: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_last) |=> grant_valid);

    a_r5_last_drops_busy: assert property (@(posedge clk) disable iff (rst)
        grant_last |-> (grant_valid && !busy));

    a_r6_reject_keeps_state: assert property (@(posedge clk) disable iff (rst)
        alloc_reject |-> (map == $past(map) && free_count == $past(free_count)));

    a_r7_err_keeps_count: assert property (@(posedge clk) disable iff (rst)
        free_err |-> $stable(free_count));

    a_r8_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_valid, alloc_reject, free_err}));
endmodule

bind frame_bitmap_alloc fba_checker #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .alloc_reject (alloc_reject),
    .grant_valid  (grant_valid),
    .grant_frame  (grant_frame),
    .grant_last   (grant_last),
    .free_err     (free_err),
    .free_count   (free_count),
    .map          (map_q)
);

// File: tb/frame_bitmap_alloc_tb_top.sv
module frame_bitmap_alloc_tb_top;
    localparam int NF    = 8;
    localparam int IDX_W = 3;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             alloc_req = 1'b0;
    logic [CNT_W-1:0] alloc_num = '0;
    logic             free_req = 1'b0;
    logic [IDX_W-1:0] free_frame = '0;
    logic             busy, alloc_reject, grant_valid, grant_last, free_err;
    logic [IDX_W-1:0] grant_frame;
    logic [CNT_W-1:0] free_count;

    int checks = 0;
    int errors = 0;
    logic [NF-1:0] mdl = '0;

    always #5 clk = ~clk;

    frame_bitmap_alloc #(.NUM_FRAMES(NF), .IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_num(alloc_num),
        .free_req(free_req), .free_frame(free_frame), .busy(busy),
        .alloc_reject(alloc_reject), .grant_valid(grant_valid),
        .grant_frame(grant_frame), .grant_last(grant_last),
        .free_err(free_err), .free_count(free_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mdl_free();
        int n = 0;
        for (int i = 0; i < NF; i++) if (!mdl[i]) n++;
        return n;
    endfunction

    function automatic int mdl_lowest();
        for (int i = 0; i < NF; i++) if (!mdl[i]) return i;
        return -1;
    endfunction

    task automatic check_count(input string req);
        chk(int'(free_count) == mdl_free(), req, int'(free_count), mdl_free());
    endtask

    // Grant stream of n frames; optionally intrude with requests while busy.
    task automatic do_alloc(input int n, input bit intrude, input bit with_free, input int ff);
        @(negedge clk);
        alloc_req = 1'b1; alloc_num = CNT_W'(n);
        free_req = with_free; free_frame = IDX_W'(ff);
        @(negedge clk);
        alloc_req = 1'b0; free_req = 1'b0;
        chk(busy == 1'b1, "R3 busy after accept", int'(busy), 1);
        chk(alloc_reject == 1'b0, "R3 no reject on accept", int'(alloc_reject), 0);
        if (with_free) chk(free_err == 1'b0, "R9 no free activity", int'(free_err), 0);
        for (int k = 0; k < n; k++) begin
            if (intrude && k == 0) begin
                alloc_req = 1'b1; alloc_num = 1; free_req = 1'b1; free_frame = 0;
            end
            @(negedge clk);
            alloc_req = 1'b0; free_req = 1'b0;
            begin
                int exp = mdl_lowest();
                chk(grant_valid == 1'b1, "R3 grant valid", int'(grant_valid), 1);
                chk(int'(grant_frame) == exp, "R4 lowest free frame", int'(grant_frame), exp);
                chk(grant_last == (k == n - 1), "R5 last marker", int'(grant_last), int'(k == n - 1));
                mdl[exp] = 1'b1;
            end
        end
        chk(busy == 1'b0, "R5 busy low with last", int'(busy), 0);
        check_count("R4 count after stream");
        @(negedge clk);
        chk(grant_valid == 1'b0, "R3 stream length", int'(grant_valid), 0);
        if (intrude) begin
            chk(busy == 1'b0 && alloc_reject == 1'b0 && free_err == 1'b0,
                "R8 requests ignored while busy", int'(busy), 0);
            check_count("R8 count unchanged by intrusion");
        end
        if (with_free) check_count("R9 free ignored");
    endtask

    task automatic do_reject(input int n);
        @(negedge clk);
        alloc_req = 1'b1; alloc_num = CNT_W'(n);
        @(negedge clk);
        alloc_req = 1'b0;
        chk(alloc_reject == 1'b1, "R6 reject pulse", int'(alloc_reject), 1);
        chk(busy == 1'b0 && grant_valid == 1'b0, "R6 no stream", int'(busy), 0);
        @(negedge clk);
        chk(alloc_reject == 1'b0, "R6 reject one cycle", int'(alloc_reject), 0);
        check_count("R6 count unchanged");
    endtask

    task automatic do_free(input int f);
        bit was_used = mdl[f];
        @(negedge clk);
        free_req = 1'b1; free_frame = IDX_W'(f);
        @(negedge clk);
        free_req = 1'b0;
        if (was_used) mdl[f] = 1'b0;
        chk(free_err == !was_used, "R7 free error flag", int'(free_err), int'(!was_used));
        check_count("R7 count after free");
        check_count("R2 count matches frames");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(int'(free_count) == NF, "R1 reset count", int'(free_count), NF);
        chk({busy, grant_valid, grant_last, alloc_reject, free_err} == '0,
            "R1 reset outputs", int'({busy, grant_valid, grant_last, alloc_reject, free_err}), 0);

        do_alloc(3, 1'b0, 1'b0, 0);   // frames 0,1,2
        do_free(1);                   // count 6
        do_free(5);                   // already free: error
        do_alloc(2, 1'b0, 1'b0, 0);   // frames 1,3 (scattered)
        do_reject(5);                 // 4 free
        do_reject(0);
        do_alloc(3, 1'b1, 1'b0, 0);   // frames 4,5,6, intrusion ignored
        do_alloc(1, 1'b0, 1'b1, 2);   // frame 7, return of 2 ignored
        do_reject(1);                 // none free
        do_free(2);
        do_alloc(1, 1'b0, 1'b0, 0);   // frame 2

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule